// File: doc/BRIEF.md
# Processor exception entry and return sequencer

This block sits beside the fetch and decode stages of a small 32-bit processor and decides, at each instruction boundary, whether an exception is taken. It watches a hardware reset request, the undefined-instruction and software-interrupt flags raised by decode, the prefetch and data abort flags raised by the memory side, and the two interrupt request lines. Only the winner is taken, chosen by a fixed priority and by the two mask bits of the current status word.

When an exception is taken, the block produces a single-cycle strobe, together with everything the register file needs for one write. This covers the PC value to load (the class's fixed vector), the new status word, the old status word for the banked saved-status register, the return link for the banked link register, and the target mode that selects the bank. For a software interrupt it also presents the service number carried in the low bits of the trapping instruction word.

When a return is flagged instead, the block copies the saved status word back into the current status and forms the resume PC from the link register minus an offset set by the class being returned from. Decode, the register file and memory are outside the block. All results appear one clock after the edge that samples the request.

Top module: `exc_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `enter_o` and `leave_o` are 0 and `pc_o`, `psr_o`, `spsr_o`, `lr_o` and `swi_num_o` are 0.
- R2: On entry, `pc_o` is the class vector and `exc_o` is the class code, which is the vector divided by 4: reset 0 (0x00), undefined 1 (0x04), software interrupt 2 (0x08), prefetch abort 3 (0x0C), data abort 4 (0x10), IRQ 6 (0x18), FIQ 7 (0x1C).
- R3: On entry, `bank_mode_o` and `psr_o[4:0]` give the target mode:
  - supervisor 10011 for reset and software interrupt
  - undefined 11011
  - abort 10111 for both aborts
  - IRQ 10010
  - FIQ 10001
- R4: On entry, `psr_o` keeps bits 31:8 of `psr_i` (flags N,Z,C,V in 31:28). It sets I (bit 7) and clears T (bit 5). It sets F (bit 6) for FIQ and reset and otherwise keeps F from `psr_i`.
- R5: On entry, `spsr_o` equals the sampled `psr_i` and `lr_o` equals the sampled `pc_i` + 4.
- R6: IRQ is taken only when `psr_i` bit 7 is 0, and FIQ only when bit 6 is 0. A masked request is not taken and does not block lower-priority requests.
- R7: The priority order is, from highest to lowest:
  1. reset
  2. data abort
  3. FIQ
  4. IRQ
  5. prefetch abort
  6. undefined instruction
  7. software interrupt
- R8: With `step_i` low (instruction not yet complete), only a reset request is taken. Every other request and any return is ignored, and `pc_o` and `psr_o` keep their values.
- R9: On a software-interrupt entry, `swi_num_o` equals the sampled `insn_lo_i`. On any other entry it is 0.
- R10: A return (`ret_i` with `step_i`, and no exception taken) pulses `leave_o`. It sets `psr_o` to the sampled `saved_psr_i`, and sets `pc_o` to `link_i` minus an offset chosen by `ret_kind_i` (coded as in R2):
  - 4 for prefetch abort, IRQ and FIQ
  - 8 for data abort
  - 0 otherwise
- R11: An exception taken in the same cycle as a return request wins, and `leave_o` stays 0.
- R12: Outputs change one clock after the sampling edge. `enter_o` and `leave_o` are one-cycle pulses, and the data outputs hold between events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| step_i | input | 1 | Current instruction completes this cycle |
| rst_req_i | input | 1 | Reset exception request |
| undef_i | input | 1 | Undefined instruction flagged |
| swi_i | input | 1 | Software-interrupt instruction flagged |
| pabt_i | input | 1 | Prefetch abort flagged |
| dabt_i | input | 1 | Data abort flagged |
| irq_i | input | 1 | Normal interrupt request |
| fiq_i | input | 1 | Fast interrupt request |
| ret_i | input | 1 | Exception return requested |
| ret_kind_i | input | 3 | Class code being returned from |
| pc_i | input | XLEN | Address of the current instruction |
| psr_i | input | XLEN | Current status word |
| insn_lo_i | input | SWI_W | Low bits of the trapping instruction word |
| saved_psr_i | input | XLEN | Saved status of the current mode |
| link_i | input | XLEN | Link register of the current mode |
| enter_o | output | 1 | Exception taken: load PC and status, write banked link and saved status |
| leave_o | output | 1 | Return taken: load PC and status |
| exc_o | output | 3 | Class code of the last exception taken |
| pc_o | output | XLEN | PC value to load |
| psr_o | output | XLEN | Status word to load |
| spsr_o | output | XLEN | Value for the banked saved-status register |
| lr_o | output | XLEN | Value for the banked link register |
| bank_mode_o | output | 5 | Mode whose bank receives the writes |
| swi_num_o | output | SWI_W | Software-interrupt service number |

## Verification
The bench builds the block with its defaults, XLEN=32 and SWI_W=24. At that size the arbitration input space is small enough to walk completely: every one of the 128 combinations of the seven request lines is driven under all four settings of the I and F mask bits, with return requests mixed in. That brings every priority pairing, every masked-interrupt fall-through and every exception-over-return collision within reach.

The same 128 combinations are then repeated with the boundary signal low, to show that only reset gets through. All eight return classes are swept for the link offset.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    EXC_RESET = 3'd0,
    EXC_UNDEF = 3'd1,
    EXC_SWI   = 3'd2,
    EXC_PABT  = 3'd3,
    EXC_DABT  = 3'd4,
    EXC_RSVD  = 3'd5,
    EXC_IRQ   = 3'd6,
    EXC_FIQ   = 3'd7
  } exc_e;

  localparam int MODE_W = 5;
  localparam int SRC_N  = 7;   // number of request sources
  localparam int PSR_I  = 7;
  localparam int PSR_F  = 6;
  localparam int PSR_T  = 5;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // privileged mode entered for each class
  function automatic logic [MODE_W-1:0] mode_of(exc_e c);
    case (c)
      EXC_UNDEF:          return MODE_UND;
      EXC_PABT, EXC_DABT: return MODE_ABT;
      EXC_IRQ:            return MODE_IRQ;
      EXC_FIQ:            return MODE_FIQ;
      default:            return MODE_SVC;
    endcase
  endfunction

  // word vector: class code times four
  function automatic logic [4:0] vec_of(exc_e c);
    return {c, 2'b00};
  endfunction

  // fast mask is also raised for these classes
  function automatic logic sets_f(exc_e c);
    return (c == EXC_FIQ) || (c == EXC_RESET);
  endfunction

  // amount subtracted from the link on return
  function automatic logic [3:0] ret_off_of(exc_e c);
    case (c)
      EXC_PABT, EXC_IRQ, EXC_FIQ: return 4'd4;
      EXC_DABT:                   return 4'd8;
      default:                    return 4'd0;
    endcase
  endfunction

  // rank 0 is the most urgent
  function automatic exc_e rank_cls(int idx);
    case (idx)
      0:       return EXC_RESET;
      1:       return EXC_DABT;
      2:       return EXC_FIQ;
      3:       return EXC_IRQ;
      4:       return EXC_PABT;
      5:       return EXC_UNDEF;
      default: return EXC_SWI;
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic step_i,
  input  logic rst_req_i,
  input  logic undef_i,
  input  logic swi_i,
  input  logic pabt_i,
  input  logic dabt_i,
  input  logic irq_i,
  input  logic fiq_i,
  input  logic irq_mask_i,
  input  logic fiq_mask_i,
  output logic hit_o,
  output exc_e cls_o
);

  // eligible requests, indexed by rank
  logic [SRC_N-1:0] elig;

  always_comb begin
    elig[0] = rst_req_i;
    elig[1] = step_i & dabt_i;
    elig[2] = step_i & fiq_i & ~fiq_mask_i;
    elig[3] = step_i & irq_i & ~irq_mask_i;
    elig[4] = step_i & pabt_i;
    elig[5] = step_i & undef_i;
    elig[6] = step_i & swi_i;
  end

  always_comb begin
    hit_o = 1'b0;
    cls_o = EXC_RESET;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit_o = 1'b1;
        cls_o = rank_cls(i);
      end
    end
  end

  always_comb begin
    if (hit_o && rst_req_i)
      assert_rst_first_R7: assert (cls_o == EXC_RESET);
    if (hit_o && cls_o == EXC_FIQ)
      assert_fiq_grant_R6: assert (fiq_i && !fiq_mask_i && !dabt_i);
    if (hit_o && cls_o == EXC_IRQ)
      assert_irq_grant_R6: assert (irq_i && !irq_mask_i);
  end

endmodule

// File: rtl/exc_psr_build.sv
module exc_psr_build
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  exc_e            cls_i,
  input  logic [XLEN-1:0] psr_i,
  output logic [XLEN-1:0] psr_o
);

  always_comb begin
    psr_o              = psr_i;
    psr_o[MODE_W-1:0]  = mode_of(cls_i);
    psr_o[PSR_I]       = 1'b1;
    psr_o[PSR_T]       = 1'b0;
    if (sets_f(cls_i))
      psr_o[PSR_F]     = 1'b1;
  end

endmodule

// File: rtl/exc_ret_calc.sv
module exc_ret_calc
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      kind_i,
  input  logic [XLEN-1:0] link_i,
  output logic [XLEN-1:0] pc_o
);

  assign pc_o = link_i - XLEN'(ret_off_of(exc_e'(kind_i)));

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int SWI_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              rst_req_i,
  input  logic              undef_i,
  input  logic              swi_i,
  input  logic              pabt_i,
  input  logic              dabt_i,
  input  logic              irq_i,
  input  logic              fiq_i,
  input  logic              ret_i,
  input  logic [2:0]        ret_kind_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   psr_i,
  input  logic [SWI_W-1:0]  insn_lo_i,
  input  logic [XLEN-1:0]   saved_psr_i,
  input  logic [XLEN-1:0]   link_i,
  output logic              enter_o,
  output logic              leave_o,
  output logic [2:0]        exc_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   psr_o,
  output logic [XLEN-1:0]   spsr_o,
  output logic [XLEN-1:0]   lr_o,
  output logic [MODE_W-1:0] bank_mode_o,
  output logic [SWI_W-1:0]  swi_num_o
);

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  function automatic logic [XLEN-1:0] link_of(logic [XLEN-1:0] pc);
    return pc + INSN_BYTES;
  endfunction

  // named internal events
  logic            take_w;
  exc_e            cls_w;
  logic            leave_w;
  logic [XLEN-1:0] entry_psr_w;
  logic [XLEN-1:0] ret_pc_w;

  exc_arbiter u_arb (
    .step_i     (step_i),
    .rst_req_i  (rst_req_i),
    .undef_i    (undef_i),
    .swi_i      (swi_i),
    .pabt_i     (pabt_i),
    .dabt_i     (dabt_i),
    .irq_i      (irq_i),
    .fiq_i      (fiq_i),
    .irq_mask_i (psr_i[PSR_I]),
    .fiq_mask_i (psr_i[PSR_F]),
    .hit_o      (take_w),
    .cls_o      (cls_w)
  );

  exc_psr_build #(.XLEN(XLEN)) u_psr (
    .cls_i (cls_w),
    .psr_i (psr_i),
    .psr_o (entry_psr_w)
  );

  exc_ret_calc #(.XLEN(XLEN)) u_ret (
    .kind_i (ret_kind_i),
    .link_i (link_i),
    .pc_o   (ret_pc_w)
  );

  assign leave_w = step_i & ret_i & ~take_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enter_o     <= 1'b0;
      leave_o     <= 1'b0;
      exc_o       <= '0;
      pc_o        <= '0;
      psr_o       <= '0;
      spsr_o      <= '0;
      lr_o        <= '0;
      bank_mode_o <= '0;
      swi_num_o   <= '0;
    end else begin
      enter_o <= take_w;
      leave_o <= leave_w;
      if (take_w) begin
        exc_o       <= cls_w;
        pc_o        <= XLEN'(vec_of(cls_w));
        psr_o       <= entry_psr_w;
        spsr_o      <= psr_i;
        lr_o        <= link_of(pc_i);
        bank_mode_o <= mode_of(cls_w);
        swi_num_o   <= (cls_w == EXC_SWI) ? insn_lo_i : '0;
      end else if (leave_w) begin
        pc_o  <= ret_pc_w;
        psr_o <= saved_psr_i;
      end
    end
  end

  assert_no_collide_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter_o && leave_o));

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_o && exc_o == EXC_IRQ) |-> !$past(psr_i[PSR_I]));

  assert_fiq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_o && exc_o == EXC_FIQ) |-> !$past(psr_i[PSR_F]));

  assert_save_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |-> (spsr_o == $past(psr_i)) && (lr_o == $past(pc_i) + INSN_BYTES));

  assert_mode_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |-> psr_o[PSR_I] && (psr_o[MODE_W-1:0] == bank_mode_o));

  assert_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    leave_o |-> psr_o == $past(saved_psr_i));

  assert_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_o && exc_o != EXC_RESET) |-> $past(step_i));

  assert_boundary_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    leave_o |-> $past(step_i) && $past(ret_i));

endmodule

// File: tb/exc_seq_bench.sv
`timescale 1ns/100ps
module exc_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i, rst_req_i, undef_i, swi_i, pabt_i, dabt_i, irq_i, fiq_i, ret_i;
  logic [2:0]  ret_kind_i;
  logic [31:0] pc_i, psr_i, saved_psr_i, link_i;
  logic [23:0] insn_lo_i;
  logic        enter_o, leave_o;
  logic [2:0]  exc_o;
  logic [31:0] pc_o, psr_o, spsr_o, lr_o;
  logic [4:0]  bank_mode_o;
  logic [23:0] swi_num_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_seq u_exc_seq (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .rst_req_i(rst_req_i),
    .undef_i(undef_i), .swi_i(swi_i), .pabt_i(pabt_i), .dabt_i(dabt_i),
    .irq_i(irq_i), .fiq_i(fiq_i), .ret_i(ret_i), .ret_kind_i(ret_kind_i),
    .pc_i(pc_i), .psr_i(psr_i), .insn_lo_i(insn_lo_i), .saved_psr_i(saved_psr_i),
    .link_i(link_i), .enter_o(enter_o), .leave_o(leave_o), .exc_o(exc_o),
    .pc_o(pc_o), .psr_o(psr_o), .spsr_o(spsr_o), .lr_o(lr_o),
    .bank_mode_o(bank_mode_o), .swi_num_o(swi_num_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // request bits: 0 reset, 1 undef, 2 swi, 3 pabt, 4 dabt, 5 irq, 6 fiq
  function automatic int winner(logic [6:0] rq, logic imask, logic fmask, logic stp);
    if (rq[0]) return 0;
    if (!stp) return -1;
    if (rq[4]) return 4;
    if (rq[6] && !fmask) return 7;
    if (rq[5] && !imask) return 6;
    if (rq[3]) return 3;
    if (rq[1]) return 1;
    if (rq[2]) return 2;
    return -1;
  endfunction

  function automatic logic [4:0] want_mode(int c);
    case (c)
      1: return 5'b11011;
      3, 4: return 5'b10111;
      6: return 5'b10010;
      7: return 5'b10001;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] back_off(int c);
    if (c == 4) return 32'd8;
    if (c == 3 || c >= 6) return 32'd4;
    return 32'd0;
  endfunction

  task automatic drive(input logic [6:0] rq, input logic stp, input logic rt, input int k,
                       input logic imask, input logic fmask);
    rst_req_i = rq[0]; undef_i = rq[1]; swi_i = rq[2]; pabt_i = rq[3];
    dabt_i = rq[4]; irq_i = rq[5]; fiq_i = rq[6];
    step_i = stp; ret_i = rt;
    ret_kind_i = 3'(k);
    psr_i = {4'(k), 20'h5A3C0 ^ 20'(k), imask, fmask, 1'b1, 5'b10000};
    pc_i = 32'h4000_2000 + 32'(k) * 4;
    insn_lo_i = 24'(k * 32'h10101);
    saved_psr_i = ~psr_i;
    link_i = 32'h4000_8000 + 32'(k) * 16;
  endtask

  task automatic check_entry(input int w);
    logic [31:0] ep;
    ep = psr_i;
    ep[4:0] = want_mode(w);
    ep[7] = 1'b1;
    ep[5] = 1'b0;
    if (w == 7 || w == 0) ep[6] = 1'b1;
    chk("R7 enter strobe", 32'(enter_o), 1);
    chk("R7 class", 32'(exc_o), 32'(w));
    chk("R2 vector", pc_o, 32'(w) * 4);
    chk("R3 bank mode", 32'(bank_mode_o), 32'(want_mode(w)));
    chk("R4 new status", psr_o, ep);
    chk("R5 saved status", spsr_o, psr_i);
    chk("R5 link", lr_o, pc_i + 4);
    chk("R9 swi number", 32'(swi_num_o), (w == 2) ? 32'(insn_lo_i) : 32'd0);
    chk("R11 no return", 32'(leave_o), 0);
  endtask

  initial begin
    logic [31:0] hold_pc, hold_psr;
    rst_n = 1'b0;
    drive(7'h0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 enter in reset", 32'(enter_o), 0);
    chk("R1 pc in reset", pc_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 enter after reset", 32'(enter_o), 0);
    chk("R1 leave after reset", 32'(leave_o), 0);
    chk("R1 status after reset", psr_o, 0);
    chk("R1 swi after reset", 32'(swi_num_o), 0);

    // full sweep: masks x requests, step high, return on some
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 128; r++) begin
        int k, w;
        logic rt;
        k = m * 128 + r;
        rt = (r % 3 == 0);
        @(negedge clk);
        drive(7'(r), 1'b1, rt, k, m[0], m[1]);
        w = winner(7'(r), m[0], m[1], 1'b1);
        @(posedge clk); #1;
        if (w >= 0) check_entry(w);
        else if (rt) begin
          chk("R10 leave strobe", 32'(leave_o), 1);
          chk("R6 masked not taken", 32'(enter_o), 0);
          chk("R10 restored status", psr_o, saved_psr_i);
          chk("R10 resume pc", pc_o, link_i - back_off(k % 8));
        end else begin
          chk("R6 nothing taken", 32'(enter_o), 0);
          chk("R12 no leave", 32'(leave_o), 0);
        end
      end
    end

    // boundary low: only reset passes
    for (int r = 0; r < 128; r++) begin
      @(negedge clk);
      hold_pc = pc_o;
      hold_psr = psr_o;
      drive(7'(r), 1'b0, 1'b1, r + 3, 1'b0, 1'b0);
      @(posedge clk); #1;
      if (r[0]) check_entry(0);
      else begin
        chk("R8 no entry off boundary", 32'(enter_o), 0);
        chk("R8 no return off boundary", 32'(leave_o), 0);
        chk("R8 pc held", pc_o, hold_pc);
        chk("R8 status held", psr_o, hold_psr);
      end
    end

    // all return classes
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      drive(7'h0, 1'b1, 1'b1, k, 1'b1, 1'b1);
      @(posedge clk); #1;
      chk("R10 return pc by class", pc_o, link_i - back_off(k));
      chk("R10 return status", psr_o, saved_psr_i);
    end

    // pulse width and hold
    @(negedge clk);
    drive(7'b0000010, 1'b1, 1'b0, 9, 1'b0, 1'b0);
    @(posedge clk); #1;
    chk("R12 entry pulse", 32'(enter_o), 1);
    @(negedge clk);
    drive(7'h0, 1'b1, 1'b0, 10, 1'b0, 1'b0);
    @(posedge clk); #1;
    chk("R12 pulse ends", 32'(enter_o), 0);
    chk("R12 vector held", pc_o, 32'h04);
    chk("R12 mode held", 32'(bank_mode_o), 32'h1B);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule